// File: doc/BRIEF.md
# Lock Detect and Test Output Pin Selector

This block drives one shared status pin for a synthesizer that holds two phase-locked loops, called PLL1 and PLL2. A four-bit selection code picks what the pin carries. The choices are a forced-low output, the lock indication of either loop, the joint lock indication of both loops, the reference-divider pulse train of either loop, or the programmable-divider pulse train of either loop. The remaining codes are test modes that ask for the counters of one or both loops to be reset. The pin is held low in those modes.

Each loop has its own lock monitor. The monitor watches the phase-detector up and down pulses and the reference-divider tick of its loop. The loop is declared locked after enough clean reference periods in a row. A clean period is one in which the phase-error pulse stays shorter than a threshold. While a loop is locked, its lock indication is high, and it drops low in every cycle that carries a phase-error pulse. When the loop is unlocked, the indication stays low.

The selection code and the routed signals are sampled on every clock. The pin and the reset requests are registered outputs.

Top module: `lockpin_mux`

## Requirements
- R1: While `rst_n` is low, `pin_out` is 0 and `cnt_rst` is 2'b00, whatever the other inputs are. After reset, both lock monitors start unlocked.
- R2: The codes 4'b0000 and 4'b1100 drive `pin_out` low, even when both loops are locked. The code bit order is [3]=divider-out select for PLL1, [2]=divider-out select for PLL2, [1]=lock select for PLL1, [0]=lock select for PLL2.
- R3: Each cycle in which `pd_up` or `pd_dn` of a loop is high adds one to that loop's error width for the current period. The period ends at that loop's `ref_tick`, and the cycle carrying the tick is counted in the period it ends. A loop becomes locked at the end of the GOOD_PERIODS-th consecutive period whose error width is below ERR_LIMIT. GOOD_PERIODS defaults to 4 and ERR_LIMIT defaults to 3.
- R4: A period whose error width reaches ERR_LIMIT unlocks the loop and restarts the count of clean periods. A width of ERR_LIMIT-1 keeps the loop locked.
- R5: While a loop is locked, its lock indication is low in each cycle in which that loop has a phase-error pulse. In other cycles the indication is high.
- R6: Code 4'b0001 selects the PLL2 lock indication. Code 4'b0010 selects the PLL1 lock indication.
- R7: Code 4'b0011 selects the logical AND of the two lock indications.
- R8: Codes matching 4'b01?0 route the PLL2 reference tick (`ref_tick[1]`) to the pin. Codes matching 4'b10?0 route the PLL1 reference tick (`ref_tick[0]`) to the pin.
- R9: Codes matching 4'b01?1 route the PLL2 programmable-divider tick (`prog_tick[1]`) to the pin. Codes matching 4'b10?1 route the PLL1 programmable-divider tick (`prog_tick[0]`) to the pin.
- R10: Code 4'b1101 sets `cnt_rst` to 2'b10 (PLL2). Code 4'b1110 sets it to 2'b01 (PLL1). Code 4'b1111 sets it to 2'b11. In these three modes `pin_out` is low. Every other code gives `cnt_rst` = 2'b00.
- R11: `pin_out` and `cnt_rst` are registered. Each reflects the code and inputs present at the previous rising clock edge, so a one-cycle tick appears on the pin for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_up | input | 2 | Phase-detector up pulse, index 0 = PLL1, index 1 = PLL2 |
| pd_dn | input | 2 | Phase-detector down pulse, same indexing |
| ref_tick | input | 2 | Reference-divider output pulse per loop |
| prog_tick | input | 2 | Programmable-divider output pulse per loop |
| sel_code | input | 4 | Pin source selection code |
| pin_out | output | 1 | Shared status pin |
| cnt_rst | output | 2 | Counter-reset request per loop |

## Verification
On every cycle, the assertions check the reset value, the forced-low codes, the routing of the divider ticks and the reset-request decode. They also check that a phase-error pulse always pulls a selected lock indication low in the following cycle. Lock acquisition needs a history of several periods, so the bench scenarios are what show it. The same holds for the exact period count before lock, loss of lock at the width threshold, survival one cycle below that threshold, and the AND of the two loops. The bench shows these by shaping error pulses per period and then observing the pin.

// File: rtl/lockpin_pkg.sv
package lockpin_pkg;

    localparam int NPLL   = 2;
    localparam int IDX_P1 = 0;
    localparam int IDX_P2 = 1;
    localparam int CODE_W = 4;

    typedef enum logic [3:0] {
        SRC_OFF,
        SRC_LD_P2,
        SRC_LD_P1,
        SRC_LD_BOTH,
        SRC_REF_P2,
        SRC_REF_P1,
        SRC_PRG_P2,
        SRC_PRG_P1,
        SRC_CLR_P2,
        SRC_CLR_P1,
        SRC_CLR_BOTH
    } src_e;

    typedef struct packed {
        logic            pin;
        logic [NPLL-1:0] clr;
    } pin_state_t;

endpackage

// File: rtl/lockpin_lock_mon.sv
module lockpin_lock_mon #(
    parameter int ERR_LIMIT    = 3,
    parameter int GOOD_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_up,
    input  logic err_dn,
    input  logic ref_tick,
    output logic lock_det
);

    localparam int WW = $clog2(ERR_LIMIT + 1);
    localparam int GW = $clog2(GOOD_PERIODS + 1);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [GW-1:0] good;
        logic          locked;
    } mon_t;

    mon_t          mon_d, mon_q;
    logic          err;
    logic [WW-1:0] width_now;
    logic          period_bad;

    always_comb begin
        err        = err_up | err_dn;
        mon_d      = mon_q;
        width_now  = mon_q.width;
        if (err && (mon_q.width != WW'(ERR_LIMIT))) begin
            width_now = mon_q.width + 1'b1;
        end
        period_bad = (width_now >= WW'(ERR_LIMIT));

        if (ref_tick) begin
            mon_d.width = '0;
            if (period_bad) begin
                mon_d.good   = '0;
                mon_d.locked = 1'b0;
            end else begin
                if (mon_q.good != GW'(GOOD_PERIODS)) begin
                    mon_d.good = mon_q.good + 1'b1;
                end
                if (mon_q.good >= GW'(GOOD_PERIODS - 1)) begin
                    mon_d.locked = 1'b1;
                end
            end
        end else begin
            mon_d.width = width_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign lock_det = mon_q.locked & ~err;

endmodule

// File: rtl/lockpin_src_dec.sv
module lockpin_src_dec
    import lockpin_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output src_e              src
);

    always_comb begin
        casez (code)
            4'b0000: src = SRC_OFF;
            4'b0001: src = SRC_LD_P2;
            4'b0010: src = SRC_LD_P1;
            4'b0011: src = SRC_LD_BOTH;
            4'b01?0: src = SRC_REF_P2;
            4'b10?0: src = SRC_REF_P1;
            4'b01?1: src = SRC_PRG_P2;
            4'b10?1: src = SRC_PRG_P1;
            4'b1101: src = SRC_CLR_P2;
            4'b1110: src = SRC_CLR_P1;
            4'b1111: src = SRC_CLR_BOTH;
            default: src = SRC_OFF;
        endcase
    end

endmodule

// File: rtl/lockpin_mux.sv
module lockpin_mux
    import lockpin_pkg::*;
#(
    parameter int ERR_LIMIT    = 3,
    parameter int GOOD_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pd_up,
    input  logic [1:0] pd_dn,
    input  logic [1:0] ref_tick,
    input  logic [1:0] prog_tick,
    input  logic [3:0] sel_code,
    output logic       pin_out,
    output logic [1:0] cnt_rst
);

    logic [NPLL-1:0] lk_det;
    src_e            src;
    pin_state_t      out_d, out_q;

    for (genvar g = 0; g < NPLL; g++) begin : g_mon
        lockpin_lock_mon #(
            .ERR_LIMIT   (ERR_LIMIT),
            .GOOD_PERIODS(GOOD_PERIODS)
        ) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .err_up  (pd_up[g]),
            .err_dn  (pd_dn[g]),
            .ref_tick(ref_tick[g]),
            .lock_det(lk_det[g])
        );
    end

    lockpin_src_dec u_dec (
        .code(sel_code),
        .src (src)
    );

    always_comb begin
        out_d = '0;
        case (src)
            SRC_OFF:      out_d.pin = 1'b0;
            SRC_LD_P2:    out_d.pin = lk_det[IDX_P2];
            SRC_LD_P1:    out_d.pin = lk_det[IDX_P1];
            SRC_LD_BOTH:  out_d.pin = lk_det[IDX_P1] & lk_det[IDX_P2];
            SRC_REF_P2:   out_d.pin = ref_tick[IDX_P2];
            SRC_REF_P1:   out_d.pin = ref_tick[IDX_P1];
            SRC_PRG_P2:   out_d.pin = prog_tick[IDX_P2];
            SRC_PRG_P1:   out_d.pin = prog_tick[IDX_P1];
            SRC_CLR_P2:   out_d.clr[IDX_P2] = 1'b1;
            SRC_CLR_P1:   out_d.clr[IDX_P1] = 1'b1;
            SRC_CLR_BOTH: out_d.clr = '1;
            default:      out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pin_out = out_q.pin;
    assign cnt_rst = out_q.clr;

endmodule

// File: rtl/lockpin_checks.sv
module lockpin_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pd_up,
    input logic [1:0] pd_dn,
    input logic [1:0] ref_tick,
    input logic [1:0] prog_tick,
    input logic [3:0] sel_code,
    input logic       pin_out,
    input logic [1:0] cnt_rst
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |-> (!pin_out && cnt_rst == 2'b00));

    p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b0000 || sel_code == 4'b1100) |=> !pin_out);

    p_dip_p1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b0010 && (pd_up[0] || pd_dn[0])) |=> !pin_out);

    p_dip_p2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b0001 && (pd_up[1] || pd_dn[1])) |=> !pin_out);

    p_ref_p2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code[3:2] == 2'b01 && !sel_code[0]) |=> (pin_out == $past(ref_tick[1])));

    p_ref_p1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code[3:2] == 2'b10 && !sel_code[0]) |=> (pin_out == $past(ref_tick[0])));

    p_prog_p2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code[3:2] == 2'b01 && sel_code[0]) |=> (pin_out == $past(prog_tick[1])));

    p_prog_p1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code[3:2] == 2'b10 && sel_code[0]) |=> (pin_out == $past(prog_tick[0])));

    p_clr_p2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b1101) |=> (cnt_rst == 2'b10 && !pin_out));

    p_clr_p1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b1110) |=> (cnt_rst == 2'b01 && !pin_out));

    p_clr_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code == 4'b1111) |=> (cnt_rst == 2'b11 && !pin_out));

    p_no_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code[3:2] != 2'b11) |=> (cnt_rst == 2'b00));

    p_clr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst != 2'b00) |-> !pin_out);

endmodule

bind lockpin_mux lockpin_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_up    (pd_up),
    .pd_dn    (pd_dn),
    .ref_tick (ref_tick),
    .prog_tick(prog_tick),
    .sel_code (sel_code),
    .pin_out  (pin_out),
    .cnt_rst  (cnt_rst)
);

// File: tb/lockpin_mux_bench.sv
module lockpin_mux_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PER_LEN    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pd_up = '0;
    logic [1:0] pd_dn = '0;
    logic [1:0] ref_tick = '0;
    logic [1:0] prog_tick = '0;
    logic [3:0] sel_code = '0;
    logic       pin_out;
    logic [1:0] cnt_rst;

    typedef struct {
        logic       pin;
        logic [1:0] clr;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lockpin_mux u_lockpin_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_up    (pd_up),
        .pd_dn    (pd_dn),
        .ref_tick (ref_tick),
        .prog_tick(prog_tick),
        .sel_code (sel_code),
        .pin_out  (pin_out),
        .cnt_rst  (cnt_rst)
    );

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic drive(input logic [1:0] up, input logic [1:0] dn,
                         input logic [1:0] rt, input logic [1:0] pt,
                         input logic [3:0] code, input bit chk,
                         input logic pin, input logic [1:0] clr,
                         input string tag);
        exp_t e;
        @(negedge clk);
        pd_up     = up;
        pd_dn     = dn;
        ref_tick  = rt;
        prog_tick = pt;
        sel_code  = code;
        if (chk) begin
            e.pin = pin;
            e.clr = clr;
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // One reference period for both loops; error pulses of widths w1 (PLL1)
    // and w2 (PLL2) at the start, both ticks in the last cycle.
    task automatic period(input int w1, input int w2, input logic [3:0] code,
                          input bit chk, input string tag);
        for (int c = 0; c < PER_LEN; c++) begin
            logic [1:0] e;
            e = {c < w2, c < w1};
            drive(e, 2'b00, (c == PER_LEN - 1) ? 2'b11 : 2'b00, 2'b00,
                  code, chk, 1'b0, 2'b00, tag);
        end
    endtask

    // Locked-loop period for PLL1 with error width w1; the pin dips while
    // the error is present.
    task automatic period_dip(input int w1, input bit use_dn,
                              input logic [3:0] code, input string tag);
        for (int c = 0; c < PER_LEN; c++) begin
            logic [1:0] e;
            e = {1'b0, c < w1};
            drive(use_dn ? 2'b00 : e, use_dn ? e : 2'b00,
                  (c == PER_LEN - 1) ? 2'b11 : 2'b00, 2'b00,
                  code, 1'b1, (c >= w1), 2'b00, tag);
        end
    endtask

    // Monitor: pops expected items and compares them after each edge.
    initial begin
        exp_t m;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                m = exp_q.pop_front();
                checks++;
                if (pin_out !== m.pin || cnt_rst !== m.clr) begin
                    errors++;
                    $display("FAIL %s: pin=%b clr=%b expected pin=%b clr=%b",
                             m.tag, pin_out, cnt_rst, m.pin, m.clr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset dominates, even with a counter-reset code applied
        for (int i = 0; i < 3; i++) begin
            drive(2'b00, 2'b00, 2'b00, 2'b11, 4'b1111, 1'b1, 1'b0, 2'b00, "R1 reset");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3: both loops unlocked after reset
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b0, 2'b00, "R3 unlocked p1");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0001, 1'b1, 1'b0, 2'b00, "R3 unlocked p2");

        // R2/R3: three clean periods on PLL1 are not enough
        for (int i = 0; i < 3; i++) period(1, 5, 4'b0000, 1'b1, "R2 off");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b0, 2'b00, "R3 three periods");
        period(1, 5, 4'b0000, 1'b1, "R2 off");

        // R3/R6/R7: PLL1 locked, PLL2 not
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b1, 2'b00, "R3 R6 p1 locked");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0001, 1'b1, 1'b0, 2'b00, "R6 p2 unlocked");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0011, 1'b1, 1'b0, 2'b00, "R7 and one locked");

        // R5: dips while locked; R4: width ERR_LIMIT-1 keeps lock
        period_dip(1, 1'b0, 4'b0010, "R5 dip up");
        period_dip(2, 1'b1, 4'b0010, "R4 R5 dip dn width2");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b1, 2'b00, "R4 still locked");

        // PLL2 acquires
        for (int i = 0; i < 4; i++) period(0, 2, 4'b0000, 1'b1, "R2 off");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0011, 1'b1, 1'b1, 2'b00, "R7 both locked");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0001, 1'b1, 1'b1, 2'b00, "R6 p2 locked");

        // R4: width ERR_LIMIT loses PLL1 lock at period end
        period_dip(3, 1'b0, 4'b0011, "R5 dip both width3");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0011, 1'b1, 1'b0, 2'b00, "R4 and after loss");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b0, 2'b00, "R4 p1 lost");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0001, 1'b1, 1'b1, 2'b00, "R6 p2 kept");

        // R3: count restarts after loss
        for (int i = 0; i < 3; i++) period(0, 0, 4'b0000, 1'b0, "");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b0, 2'b00, "R3 relock three");
        period(0, 0, 4'b0000, 1'b0, "");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0010, 1'b1, 1'b1, 2'b00, "R3 relock four");

        // R8: reference tick routing
        drive(2'b00, 2'b00, 2'b10, 2'b01, 4'b0100, 1'b1, 1'b1, 2'b00, "R8 ref p2");
        drive(2'b00, 2'b00, 2'b01, 2'b10, 4'b0100, 1'b1, 1'b0, 2'b00, "R8 ref p2 other");
        drive(2'b00, 2'b00, 2'b10, 2'b00, 4'b0110, 1'b1, 1'b1, 2'b00, "R8 ref p2 x1");
        drive(2'b00, 2'b00, 2'b01, 2'b10, 4'b1000, 1'b1, 1'b1, 2'b00, "R8 ref p1");
        drive(2'b00, 2'b00, 2'b10, 2'b01, 4'b1000, 1'b1, 1'b0, 2'b00, "R8 ref p1 other");
        drive(2'b00, 2'b00, 2'b01, 2'b00, 4'b1010, 1'b1, 1'b1, 2'b00, "R8 ref p1 x1");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b1000, 1'b1, 1'b0, 2'b00, "R11 tick one cycle");

        // R9: programmable tick routing
        drive(2'b00, 2'b00, 2'b01, 2'b10, 4'b0101, 1'b1, 1'b1, 2'b00, "R9 prog p2");
        drive(2'b00, 2'b00, 2'b10, 2'b01, 4'b0101, 1'b1, 1'b0, 2'b00, "R9 prog p2 other");
        drive(2'b00, 2'b00, 2'b00, 2'b10, 4'b0111, 1'b1, 1'b1, 2'b00, "R9 prog p2 x1");
        drive(2'b00, 2'b00, 2'b10, 2'b01, 4'b1001, 1'b1, 1'b1, 2'b00, "R9 prog p1");
        drive(2'b00, 2'b00, 2'b01, 2'b10, 4'b1001, 1'b1, 1'b0, 2'b00, "R9 prog p1 other");
        drive(2'b00, 2'b00, 2'b11, 2'b00, 4'b1011, 1'b1, 1'b0, 2'b00, "R9 prog not ref");

        // R10: counter-reset test modes
        drive(2'b00, 2'b00, 2'b11, 2'b11, 4'b1101, 1'b1, 1'b0, 2'b10, "R10 clr p2");
        drive(2'b00, 2'b00, 2'b11, 2'b11, 4'b1110, 1'b1, 1'b0, 2'b01, "R10 clr p1");
        drive(2'b00, 2'b00, 2'b11, 2'b11, 4'b1111, 1'b1, 1'b0, 2'b11, "R10 clr both");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b1100, 1'b1, 1'b0, 2'b00, "R2 unused code");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0011, 1'b1, 1'b1, 2'b00, "R10 R11 clr released");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b1, 1'b0, 2'b00, "R2 off both locked");

        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 1'b0, 2'b00, "");
        drive(2'b00, 2'b00, 2'b00, 2'b00, 4'b0000, 1'b0, 1'b0, 2'b00, "");
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d results never observed, expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule